// File: doc/BRIEF.md
# Color Lookup Table with Sequenced Host Loading

This block holds a 256-entry color lookup table whose entries are three 6-bit components (red, green, blue). A host loads it through two byte-wide ports. A write to the index port chooses the entry to update. Three writes to the data port then supply that entry's components, red first, then green, then blue. The entry is written as one unit when the blue byte arrives. The index then advances by one, so a whole table can be loaded with one index write followed by a continuous stream of data bytes.

On the display side, a pixel stream presents 8-bit indices with a valid flag. Each index is ANDed with a host-programmable mask before the table is read. The 18-bit color comes out one clock later with its own valid flag. The pixel stream has no ready signal and so cannot apply back-pressure. Every valid index produces a color on the following cycle, and the consumer must take it. When no index is valid, the color outputs keep their last value.

Top module: `pal_dac_wr`

## Requirements
- R1: After reset the load index is 0, the component sequence waits for red, the mask is 0xFF, every entry reads as zero, and `col_valid` is 0.
- R2: A write to the index port selects the entry for the following data writes and restarts the sequence at red, discarding any red or green already received. If an index write and a data write occur in the same cycle, the index write wins and the data byte is dropped.
- R3: Data writes are taken as red, then green, then blue. The entry changes only when the blue byte is accepted, and all three components are updated together.
- R4: Only bits 5:0 of each data byte are stored. Bits 7:6 have no effect.
- R5: After a blue byte is accepted, the load index increments by one and wraps from 255 to 0.
- R6: A write to the mask port sets the mask from the next cycle. A lookup reads the entry at `pix_idx & mask`.
- R7: `col_valid` is 1 exactly one cycle after a cycle with `pix_valid` high, and then carries that lookup's color. Otherwise `col_valid` is 0 and the color outputs hold their value.
- R8: A lookup of an entry in the same cycle that its blue byte is committed returns the entry's previous content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr_en | input | 1 | Index port write strobe |
| idx_wr_data | input | 8 | Entry index to load next |
| dat_wr_en | input | 1 | Data port write strobe |
| dat_wr_data | input | 8 | Component byte; bits 5:0 are used |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_data | input | 8 | New pixel mask |
| pix_valid | input | 1 | Pixel index valid |
| pix_idx | input | 8 | Pixel index to look up |
| col_valid | output | 1 | Color valid, one cycle after `pix_valid` |
| col_red | output | 6 | Red component of the looked-up entry |
| col_green | output | 6 | Green component |
| col_blue | output | 6 | Blue component |

## Verification
The assertions check several properties on every cycle. These include the one-cycle valid relationship and the holding of the color outputs between lookups. They also cover the restart to red after an index write, the legality of the sequence state, the index step after every commit, and the capture of mask writes. Other behaviour is visible only through the bench's scenarios, because it depends on the table's content. This covers whether components land in the right entry and field, whether the upper data bits are dropped, and whether the mask is applied. It also covers the wrap from 255 to 0, the dropped byte on a colliding write, and the old value returned by a read during a commit.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int PAL_COMP_W = 6;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } pal_phase_t;

  typedef struct packed {
    logic [PAL_COMP_W-1:0] red;
    logic [PAL_COMP_W-1:0] green;
    logic [PAL_COMP_W-1:0] blue;
  } pal_rgb_t;
endpackage

// File: rtl/pal_wr_seq.sv
module pal_wr_seq
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr_en,
  input  logic [IDX_W-1:0]  idx_wr_data,
  input  logic              dat_wr_en,
  input  logic [DATA_W-1:0] dat_wr_data,
  output logic              commit,
  output logic [IDX_W-1:0]  commit_idx,
  output pal_rgb_t          commit_rgb
);
  localparam int CW = PAL_COMP_W;

  pal_phase_t         phase;
  logic [IDX_W-1:0]   wr_idx;
  logic [CW-1:0]      red_q, green_q;
  logic [CW-1:0]      byte_comp;

  assign byte_comp = dat_wr_data[CW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_RED;
      wr_idx  <= '0;
      red_q   <= '0;
      green_q <= '0;
    end else if (idx_wr_en) begin
      wr_idx <= idx_wr_data;
      phase  <= PH_RED;
    end else if (dat_wr_en) begin
      case (phase)
        PH_RED: begin
          red_q <= byte_comp;
          phase <= PH_GREEN;
        end
        PH_GREEN: begin
          green_q <= byte_comp;
          phase   <= PH_BLUE;
        end
        default: begin
          phase  <= PH_RED;
          wr_idx <= wr_idx + 1'b1;
        end
      endcase
    end
  end

  assign commit     = dat_wr_en && !idx_wr_en && (phase == PH_BLUE);
  assign commit_idx = wr_idx;
  assign commit_rgb = '{red: red_q, green: green_q, blue: byte_comp};

  AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr_en |=> (phase == PH_RED) && (wr_idx == $past(idx_wr_data))); // R2
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (wr_idx == IDX_W'($past(commit_idx) + 1'b1))); // R5
endmodule

// File: rtl/pal_lut.sv
module pal_lut
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [IDX_W-1:0] commit_idx,
  input  pal_rgb_t         commit_rgb,
  input  logic             mask_wr_en,
  input  logic [IDX_W-1:0] mask_wr_data,
  input  logic             pix_valid,
  input  logic [IDX_W-1:0] pix_idx,
  output logic             col_valid,
  output pal_rgb_t         col_rgb
);
  localparam int DEPTH = 1 << IDX_W;

  pal_rgb_t         table_q [DEPTH];
  logic [IDX_W-1:0] mask_q;
  logic [IDX_W-1:0] rd_addr;

  assign rd_addr = pix_idx & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) table_q[k] <= '0;
    end else if (commit) begin
      table_q[commit_idx] <= commit_rgb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '1;
      col_valid <= 1'b0;
      col_rgb   <= '0;
    end else begin
      if (mask_wr_en) mask_q <= mask_wr_data;
      col_valid <= pix_valid;
      if (pix_valid) col_rgb <= table_q[rd_addr];
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> col_valid); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !col_valid && $stable(col_rgb)); // R7
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_en |=> (mask_q == $past(mask_wr_data))); // R6
endmodule

// File: rtl/pal_dac_wr.sv
module pal_dac_wr
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  idx_wr_en,
  input  logic [IDX_W-1:0]      idx_wr_data,
  input  logic                  dat_wr_en,
  input  logic [DATA_W-1:0]     dat_wr_data,
  input  logic                  mask_wr_en,
  input  logic [IDX_W-1:0]      mask_wr_data,
  input  logic                  pix_valid,
  input  logic [IDX_W-1:0]      pix_idx,
  output logic                  col_valid,
  output logic [PAL_COMP_W-1:0] col_red,
  output logic [PAL_COMP_W-1:0] col_green,
  output logic [PAL_COMP_W-1:0] col_blue
);
  logic             commit;
  logic [IDX_W-1:0] commit_idx;
  pal_rgb_t         commit_rgb;
  pal_rgb_t         col_rgb;

  pal_wr_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .idx_wr_en   (idx_wr_en),
    .idx_wr_data (idx_wr_data),
    .dat_wr_en   (dat_wr_en),
    .dat_wr_data (dat_wr_data),
    .commit      (commit),
    .commit_idx  (commit_idx),
    .commit_rgb  (commit_rgb)
  );

  pal_lut #(.IDX_W(IDX_W)) u_lut (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit       (commit),
    .commit_idx   (commit_idx),
    .commit_rgb   (commit_rgb),
    .mask_wr_en   (mask_wr_en),
    .mask_wr_data (mask_wr_data),
    .pix_valid    (pix_valid),
    .pix_idx      (pix_idx),
    .col_valid    (col_valid),
    .col_rgb      (col_rgb)
  );

  assign col_red   = col_rgb.red;
  assign col_green = col_rgb.green;
  assign col_blue  = col_rgb.blue;
endmodule

// File: tb/pal_dac_wr_bench.sv
module pal_dac_wr_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idx_wr_en = 1'b0;
  logic [7:0] idx_wr_data = '0;
  logic       dat_wr_en = 1'b0;
  logic [7:0] dat_wr_data = '0;
  logic       mask_wr_en = 1'b0;
  logic [7:0] mask_wr_data = '0;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_idx = '0;
  logic       col_valid;
  logic [5:0] col_red, col_green, col_blue;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [17:0] model [256];
  logic [7:0]  model_idx;

  always #5 clk = ~clk;

  pal_dac_wr u_pal_dac_wr (
    .clk(clk), .rst_n(rst_n),
    .idx_wr_en(idx_wr_en), .idx_wr_data(idx_wr_data),
    .dat_wr_en(dat_wr_en), .dat_wr_data(dat_wr_data),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .pix_valid(pix_valid), .pix_idx(pix_idx),
    .col_valid(col_valid), .col_red(col_red),
    .col_green(col_green), .col_blue(col_blue)
  );

  function automatic logic [5:0] pr(int i); return 6'((i * 5 + 3) % 64);  endfunction
  function automatic logic [5:0] pg(int i); return 6'((i * 11 + 7) % 64); endfunction
  function automatic logic [5:0] pb(int i); return 6'((i * 3 + 60) % 64); endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_idx(logic [7:0] v);
    @(negedge clk); idx_wr_en = 1'b1; idx_wr_data = v;
    @(negedge clk); idx_wr_en = 1'b0;
    model_idx = v;
  endtask

  task automatic host_dat(logic [7:0] v);
    @(negedge clk); dat_wr_en = 1'b1; dat_wr_data = v;
    @(negedge clk); dat_wr_en = 1'b0;
  endtask

  task automatic host_entry(logic [5:0] r, logic [5:0] g, logic [5:0] b, logic [1:0] hi);
    host_dat({hi, r}); host_dat({~hi, g}); host_dat({hi, b});
    model[model_idx] = {r, g, b};
    model_idx = model_idx + 8'd1;
  endtask

  task automatic host_mask(logic [7:0] v);
    @(negedge clk); mask_wr_en = 1'b1; mask_wr_data = v;
    @(negedge clk); mask_wr_en = 1'b0;
  endtask

  task automatic lookup(logic [7:0] p, logic [17:0] exp, string tag);
    @(negedge clk); pix_valid = 1'b1; pix_idx = p;
    @(negedge clk); pix_valid = 1'b0;
    check(col_valid === 1'b1 && {col_red, col_green, col_blue} === exp, tag,
          {13'd0, col_valid, col_red, col_green, col_blue}, {13'd0, 1'b1, exp});
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    model_idx = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(col_valid === 1'b0, "R1 col_valid at reset", {31'd0, col_valid}, 0);
    lookup(8'd5, 18'd0, "R1 entry zero at reset");
    lookup(8'd200, 18'd0, "R1 entry zero at reset");

    // R3 R4 R5: one index write then a full auto-incrementing load
    host_idx(8'd0);
    for (int i = 0; i < 256; i++) host_entry(pr(i), pg(i), pb(i), 2'(i));
    for (int i = 0; i < 256; i++) lookup(8'(i), {pr(i), pg(i), pb(i)}, "R3 R4 full load");

    // R5 wrap: index is back at 0
    host_entry(6'd1, 6'd2, 6'd3, 2'b11);
    lookup(8'd0, {6'd1, 6'd2, 6'd3}, "R5 wrap to entry 0");
    lookup(8'd1, {pr(1), pg(1), pb(1)}, "R5 entry 1 untouched");

    // R3: partial sequence leaves entry unchanged; R2 restart
    host_idx(8'd10);
    host_dat(8'h09);
    lookup(8'd10, model[10], "R3 no update before blue");
    host_dat(8'h0A);
    lookup(8'd10, model[10], "R3 no update before blue");
    host_idx(8'd20);
    host_entry(6'd4, 6'd5, 6'd6, 2'b00);
    lookup(8'd20, {6'd4, 6'd5, 6'd6}, "R2 restart at red");
    lookup(8'd10, model[10], "R2 abandoned entry unchanged");

    // R2: colliding index and data write, data dropped
    @(negedge clk); idx_wr_en = 1'b1; idx_wr_data = 8'd30;
    dat_wr_en = 1'b1; dat_wr_data = 8'h3F;
    @(negedge clk); idx_wr_en = 1'b0; dat_wr_en = 1'b0;
    model_idx = 8'd30;
    host_entry(6'd7, 6'd8, 6'd9, 2'b10);
    lookup(8'd30, {6'd7, 6'd8, 6'd9}, "R2 colliding data dropped");

    // R6: mask sweeps
    host_mask(8'h0F);
    for (int p = 0; p < 256; p++) lookup(8'(p), model[p & 8'h0F], "R6 mask 0F");
    host_mask(8'h00);
    for (int p = 0; p < 256; p += 7) lookup(8'(p), model[0], "R6 mask 00");
    host_mask(8'hF0);
    for (int p = 0; p < 256; p += 5) lookup(8'(p), model[p & 8'hF0], "R6 mask F0");
    host_mask(8'hFF);

    // R7: outputs hold while idle
    lookup(8'd77, model[77], "R7 lookup");
    repeat (3) @(negedge clk);
    check(col_valid === 1'b0, "R7 valid drops", {31'd0, col_valid}, 0);
    check({col_red, col_green, col_blue} === model[77], "R7 color held",
          {14'd0, col_red, col_green, col_blue}, {14'd0, model[77]});

    // R8: read during commit returns old content
    host_idx(8'd40);
    host_dat(8'h11); host_dat(8'h22);
    @(negedge clk); dat_wr_en = 1'b1; dat_wr_data = 8'h33;
    pix_valid = 1'b1; pix_idx = 8'd40;
    @(negedge clk); dat_wr_en = 1'b0; pix_valid = 1'b0;
    check({col_red, col_green, col_blue} === model[40], "R8 old content",
          {14'd0, col_red, col_green, col_blue}, {14'd0, model[40]});
    model[40] = {6'h11, 6'h22, 6'h33};
    lookup(8'd40, model[40], "R8 new content after");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule